// File: doc/BRIEF.md
# APB Down-Counting Timer

This block is a single 32-bit timer that counts down by one on every clock while it is enabled. It sits on an APB slave port. Software programs a load value, picks a mode, and sets the enable bit. When the count passes zero, the next clock reloads the counter. In periodic mode the reload value is the load register. In free-running mode it is all ones, so the bitwise inverse of the current value gives the elapsed clock count. Each expiry sets a raw interrupt flag. The flag drives a level interrupt output unless the active-high mask bit is set. Software clears the flag by reading either of two end-of-interrupt addresses.

The counter is controlled by a two-state machine. In `ST_IDLE` the timer is disabled and the count holds. In `ST_COUNT` the timer is running. The transition `T_START` (ST_IDLE to ST_COUNT) happens on the first clock that sees the enable bit set, and it copies the load register into the counter. The transition `T_WRAP` (ST_COUNT to ST_COUNT) happens at zero and performs the mode-dependent reload. The transition `T_STOP` (ST_COUNT to ST_IDLE) happens when the enable bit is cleared, and it leaves the count frozen. Because of this, every disable-then-enable sequence restarts the timer from the load value.

Top module: `apb_dcount_timer`

## Requirements
- R1: The address map is as follows. Offset 0x00 is the 32-bit read/write load value. Offset 0x08 is the control register: bit 0 is enable, bit 1 is mode (1 for periodic, 0 for free-running), bit 2 is mask, and bits 31:3 read as zero. Offset 0x04 reads the current count. Offset 0xAC returns the fixed VERSION constant. Unmapped offsets read zero.
- R2: When the enable bit is seen set while the timer is idle, the next clock loads the counter from the load register. Each later enabled clock lowers the count by one.
- R3: In periodic mode, an enabled clock at count zero reloads the load value and sets the raw flag. The flag therefore rises load+2 clocks after the enabling write.
- R4: In free-running mode, an enabled clock at count zero reloads 0xFFFFFFFF and sets the raw flag.
- R5: While the mask bit is 1, `timer_irq` stays low, but the raw flag at 0xA8 bit 0 still records expiries. Offsets 0x10 and 0xA0 return raw AND NOT mask in bit 0.
- R6: A read of 0x0C or 0xA4 returns zero and clears the raw flag. If an expiry falls on the same clock, the expiry wins. The read changes nothing else.
- R7: While the enable bit is 0, the count holds its value.
- R8: Every access completes with `pready` high and `pslverr` low. Writes to 0x04, 0x0C, 0x10 and 0xA0 to 0xAC have no effect.
- R9: After reset, the load value, control, count and raw flag are all zero, and `timer_irq` is low.
- R10: In the global status registers (0xA0, 0xA8), only bit 0 can be nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the timer counts one per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | DW | APB write data |
| prdata | output | DW | APB read data |
| pready | output | 1 | Always high (zero wait states) |
| pslverr | output | 1 | Always low |
| timer_irq | output | 1 | Level interrupt, raw flag gated by mask |

## Verification
The hardest states to reach are the two reload paths at count zero. With a large load value, the first wrap would take billions of cycles. The bench therefore programs small load values while the timer is disabled, enables it, and counts clocks until the interrupt rises. This confirms the load+2 latency of `T_START` followed by the wrap. Right after a free-running wrap, the bench reads the counter and expects 0xFFFFFFFE, which proves the all-ones reload. A masked run confirms that the raw flag sets while the output stays low. The bench then disables the timer before the end-of-interrupt read, so that no fresh expiry can hide whether the clear took effect.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EOI   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_GSTAT = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_GEOI  = 8'hA4;
    localparam logic [ADDR_W-1:0] OFS_GRAW  = 8'hA8;
    localparam logic [ADDR_W-1:0] OFS_VER   = 8'hAC;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_COUNT = 1'b1
    } cnt_state_e;

    typedef struct packed {
        logic mask;
        logic periodic;
        logic enable;
    } ctrl_t;
endpackage

// File: rtl/dct_regbank.sv
module dct_regbank
    import dct_pkg::*;
#(
    parameter int unsigned   DW      = 32,
    parameter logic [DW-1:0] VERSION = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    output logic [DW-1:0]     load_o,
    output ctrl_t             ctrl_o,
    input  logic [DW-1:0]     count_i,
    input  logic              raw_i,
    output logic              eoi_o
);
    localparam int unsigned CTRL_W = $bits(ctrl_t);

    logic wr_acc;
    logic rd_acc;
    logic masked;

    assign wr_acc = psel && penable && pwrite;
    assign rd_acc = psel && penable && !pwrite;
    assign masked = raw_i && !ctrl_o.mask;
    assign eoi_o  = rd_acc && ((paddr == OFS_EOI) || (paddr == OFS_GEOI));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_o <= '0;
            ctrl_o <= '0;
        end else if (wr_acc) begin
            if (paddr == OFS_LOAD) load_o <= pwdata;
            if (paddr == OFS_CTRL) ctrl_o <= ctrl_t'(pwdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        prdata = '0;
        if (rd_acc) begin
            case (paddr)
                OFS_LOAD:  prdata = load_o;
                OFS_COUNT: prdata = count_i;
                OFS_CTRL:  prdata = {{(DW-CTRL_W){1'b0}}, ctrl_o};
                OFS_STAT:  prdata = {{(DW-1){1'b0}}, masked};
                OFS_GSTAT: prdata = {{(DW-1){1'b0}}, masked};
                OFS_GRAW:  prdata = {{(DW-1){1'b0}}, raw_i};
                OFS_VER:   prdata = VERSION;
                default:   prdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dct_counter.sv
module dct_counter
    import dct_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          periodic_i,
    input  logic [DW-1:0] load_i,
    output logic [DW-1:0] count_o,
    output logic          expire_o,
    output logic          running_o
);
    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

    cnt_state_e state_q;
    cnt_state_e state_d;
    logic       at_zero;

    assign at_zero = (count_o == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (enable_i)  state_d = ST_COUNT;   // T_START
            ST_COUNT: if (!enable_i) state_d = ST_IDLE;    // T_STOP
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (enable_i) count_o <= load_i;
                end
                ST_COUNT: begin
                    if (enable_i) begin
                        if (at_zero) count_o <= periodic_i ? load_i : ALL_ONES; // T_WRAP
                        else         count_o <= count_o - 1'b1;
                    end
                end
            endcase
        end
    end

    assign expire_o  = (state_q == ST_COUNT) && enable_i && at_zero;
    assign running_o = (state_q == ST_COUNT);
endmodule

// File: rtl/dct_irq.sv
module dct_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clear_i,
    input  logic mask_i,
    output logic raw_o,
    output logic irq_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        raw_o <= 1'b0;
        else if (expire_i) raw_o <= 1'b1;
        else if (clear_i)  raw_o <= 1'b0;
    end

    assign irq_o = raw_o && !mask_i;
endmodule

// File: rtl/apb_dcount_timer.sv
module apb_dcount_timer
    import dct_pkg::*;
#(
    parameter int unsigned   DW      = 32,
    parameter logic [DW-1:0] VERSION = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              timer_irq
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] load_q;
    logic [DW-1:0] count_q;
    logic          raw_q;
    logic          expire;
    logic          running;
    logic          eoi_clr;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    dct_regbank #(.DW(DW), .VERSION(VERSION)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .load_o  (load_q),
        .ctrl_o  (ctrl_q),
        .count_i (count_q),
        .raw_i   (raw_q),
        .eoi_o   (eoi_clr)
    );

    dct_counter #(.DW(DW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (ctrl_q.enable),
        .periodic_i (ctrl_q.periodic),
        .load_i     (load_q),
        .count_o    (count_q),
        .expire_o   (expire),
        .running_o  (running)
    );

    dct_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clear_i  (eoi_clr),
        .mask_i   (ctrl_q.mask),
        .raw_o    (raw_q),
        .irq_o    (timer_irq)
    );
endmodule

// File: rtl/apb_dcount_timer_chk.sv
module apb_dcount_timer_chk #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          psel,
    input logic          penable,
    input logic          pwrite,
    input logic [7:0]    paddr,
    input logic          pready,
    input logic          pslverr,
    input logic          timer_irq,
    input logic [2:0]    ctrl,
    input logic [DW-1:0] load,
    input logic [DW-1:0] count,
    input logic          raw,
    input logic          running
);
    logic en, per, msk, eoi_rd, wrap_now;
    assign en       = ctrl[0];
    assign per      = ctrl[1];
    assign msk      = ctrl[2];
    assign eoi_rd   = psel && penable && !pwrite && (paddr == 8'h0C || paddr == 8'hA4);
    assign wrap_now = running && en && (count == '0);

    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && en) |=> (running && count == $past(load)));

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (running && en && count != '0) |=> (count == $past(count) - 1'b1));

    a_r3_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_now && per) |=> (count == $past(load) && raw));

    a_r4_free_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_now && !per) |=> (count == {DW{1'b1}} && raw));

    a_r5_masked_low: assert property (@(posedge clk) disable iff (!rst_n)
        msk |-> !timer_irq);

    a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_rd && !wrap_now) |=> !raw);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

    a_r8_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (pready && !pslverr));
endmodule

bind apb_dcount_timer apb_dcount_timer_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pready    (pready),
    .pslverr   (pslverr),
    .timer_irq (timer_irq),
    .ctrl      (ctrl_q),
    .load      (load_q),
    .count     (count_q),
    .raw       (raw_q),
    .running   (running)
);

// File: tb/apb_dcount_timer_tb.sv
module apb_dcount_timer_tb;
    localparam logic [31:0] VER = 32'h0001_0203;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, timer_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    apb_dcount_timer #(.DW(32), .VERSION(VER)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .timer_irq(timer_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h00, 32'hDEADBEEF, 32'h0, 8'd1},
        '{1'b0, 8'h00, 32'h0, 32'hDEADBEEF, 8'd1},   // R1 load read/write
        '{1'b1, 8'h08, 32'hFFFFFFF8, 32'h0, 8'd1},
        '{1'b0, 8'h08, 32'h0, 32'h0, 8'd1},          // R1 upper ctrl bits zero
        '{1'b1, 8'h08, 32'h00000006, 32'h0, 8'd1},
        '{1'b0, 8'h08, 32'h0, 32'h6, 8'd1},          // R1 ctrl fields
        '{1'b1, 8'h04, 32'h00000055, 32'h0, 8'd8},
        '{1'b0, 8'h04, 32'h0, 32'h0, 8'd8},          // R8 count read-only
        '{1'b1, 8'hAC, 32'h0, 32'h0, 8'd8},
        '{1'b0, 8'hAC, 32'h0, VER, 8'd1},            // R1 version constant
        '{1'b1, 8'hA8, 32'hFFFFFFFF, 32'h0, 8'd8},
        '{1'b0, 8'hA8, 32'h0, 32'h0, 8'd10},         // R10 raw register
        '{1'b0, 8'hA0, 32'h0, 32'h0, 8'd10},         // R10 global status
        '{1'b0, 8'h0C, 32'h0, 32'h0, 8'd6},          // R6 eoi reads zero
        '{1'b1, 8'h08, 32'h0, 32'h0, 8'd1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge clk); @(negedge clk);
        penable = 1'b1;
        @(posedge clk); @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(posedge clk); @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(posedge clk); @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!timer_irq && n < 100);
    endtask

    initial begin : wd
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d, d2;
        int n;
        int seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        check("R9 irq", {31'b0, timer_irq}, 32'h0);
        apb_rd(8'h00, d); check("R9 load", d, 32'h0);
        apb_rd(8'h08, d); check("R9 ctrl", d, 32'h0);
        apb_rd(8'h04, d); check("R9 count", d, 32'h0);
        apb_rd(8'hA8, d); check("R9 raw", d, 32'h0);

        // register table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) apb_wr(VECS[i].addr, VECS[i].data);
            else begin
                apb_rd(VECS[i].addr, d);
                check($sformatf("R%0d table %0d", VECS[i].req, i), d, VECS[i].exp);
            end
        end

        // R8 handshake during an access
        psel = 1'b1; penable = 1'b1; #1;
        check("R8 ready/err", {30'b0, pready, pslverr}, 32'h2);
        psel = 1'b0; penable = 1'b0;
        @(negedge clk);

        // R3 periodic with load 3
        apb_wr(8'h00, 32'd3);
        apb_wr(8'h08, 32'h3);
        wait_irq(n);
        check("R3 first expiry latency", n, 32'd5);
        apb_rd(8'h0C, d);
        check("R6 eoi data", d, 32'h0);
        check("R6 irq cleared", {31'b0, timer_irq}, 32'h0);
        wait_irq(n);
        check("R3 next expiry after clear", n, 32'd2);
        apb_rd(8'h08, d);
        check("R6 ctrl unchanged", d, 32'h3);

        // R2 consecutive reads drop by two
        apb_rd(8'h0C, d);
        apb_wr(8'h08, 32'h0);
        apb_wr(8'h00, 32'd40);
        apb_wr(8'h08, 32'h3);
        apb_rd(8'h04, d);
        check("R2 loaded", d, 32'd40);
        apb_rd(8'h04, d);
        check("R2 decrement", d, 32'd38);

        // R5 mask
        apb_wr(8'h00, 32'd3);
        apb_wr(8'h08, 32'h0);
        apb_wr(8'h08, 32'h7);
        seen = 0;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk); @(negedge clk);
            if (timer_irq) seen++;
        end
        check("R5 irq masked", seen, 32'd0);
        apb_rd(8'hA8, d); check("R5 raw still set", d, 32'h1);
        apb_rd(8'h10, d); check("R5 masked status", d, 32'h0);
        apb_rd(8'hA0, d); check("R5 global masked status", d, 32'h0);

        // R6 global eoi with timer disabled, R7 hold
        apb_wr(8'h08, 32'h6);
        apb_rd(8'hA4, d); check("R6 global eoi data", d, 32'h0);
        apb_rd(8'hA8, d); check("R6 raw cleared", d, 32'h0);
        apb_rd(8'h04, d);
        repeat (5) @(negedge clk);
        apb_rd(8'h04, d2);
        check("R7 count held", d2, d);
        apb_rd(8'h08, d); check("R6 ctrl unchanged by eoi", d, 32'h6);

        // R4 free-running with load 2
        apb_wr(8'h00, 32'd2);
        apb_wr(8'h08, 32'h1);
        wait_irq(n);
        check("R4 expiry latency", n, 32'd4);
        apb_rd(8'h04, d);
        check("R4 reload all ones", d, 32'hFFFFFFFE);
        apb_rd(8'h10, d); check("R10 status bit0", d, 32'h1);
        apb_rd(8'hA0, d); check("R10 global status bit0", d, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule